// File: doc/BRIEF.md
# Paired-Page TLB Lookup Unit

This block is a fully associative translation lookaside buffer. Every entry describes two neighbouring virtual pages, an even one and an odd one, that share a single virtual tag, an address-space identifier, a global flag and a page-size mask. Each of the two halves has its own physical frame number, its own valid bit and its own dirty (writable) bit. The page size is chosen per entry: 4 KB when the mask field is zero, and four times larger for each further pair of mask bits.

A lookup request carries a virtual address, the current 8-bit address-space identifier and a flag that marks a store. One cycle later the unit reports one of four outcomes: a hit with a physical address, no matching entry, a match on a half that is not valid, or a store to a half that is not yet writable. Entries are loaded through an indexed write port. Choosing which entry to replace and handling the resulting faults belong to the surrounding logic.

Top module: `tlbp_lookup_unit`

## Requirements
- R1: Reset clears every entry field to zero and drops `rsp_valid`. A lookup of virtual address 0x0000_0000 with identifier 0 then gives INVALID, and any address at or above 0x0000_2000 gives MISS.
- R2: `rsp_valid` is high in exactly the cycle after a cycle with `req_valid` high. The response fields belong to that request. A request issued in the same cycle as a table write sees the old contents.
- R3: An entry matches when its global bit is set or its stored identifier equals `req_asid`, and when `req_va[31:13]` equals the stored tag at every bit position where the mask field is 0. Tag bits under set mask bits are ignored.
- R4: The mask field is aligned to `req_va[31:13]` and must hold ones from its bit 0 upward. With k ones, the page size is 4 KB << k. The odd half is selected when `req_va[12+k]` is 1, and the even half when it is 0.
- R5: A match whose selected half has its valid bit clear gives result code 2 (INVALID).
- R6: A read, or a store to a half with its dirty bit set, gives code 0 (HIT). The physical address is then (frame number << 12) OR (`req_va` modulo the page size). For every other code `rsp_pa` is 0.
- R7: A store to a valid half whose dirty bit is clear gives code 3 (MODIFIED). A read never gives code 3.
- R8: `rsp_wr_ok` is 1 only on a HIT whose selected half has its dirty bit set. Read permission is implied by every HIT.
- R9: When no entry matches, the result is code 1 (MISS).
- R10: When several entries match, the entry with the lowest index decides the result.
- R11: A write with `wr_en` high replaces every field of entry `wr_idx` at the clock edge. Lookups issued from the next cycle on use the new contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Lookup request strobe |
| req_va | input | 32 | Virtual address to translate |
| req_asid | input | 8 | Current address-space identifier |
| req_write | input | 1 | 1 for a store, 0 for a read |
| wr_en | input | 1 | Entry write strobe |
| wr_idx | input | 4 | Entry index to write |
| wr_vpn2 | input | 19 | Virtual tag of the page pair (address bits 31:13) |
| wr_asid | input | 8 | Identifier of the entry |
| wr_global | input | 1 | Entry matches any identifier |
| wr_mask | input | 19 | Page-size mask, aligned to address bits 31:13 |
| wr_pfn_even | input | 20 | Frame number of the even half |
| wr_valid_even | input | 1 | Even half valid |
| wr_dirty_even | input | 1 | Even half writable |
| wr_pfn_odd | input | 20 | Frame number of the odd half |
| wr_valid_odd | input | 1 | Odd half valid |
| wr_dirty_odd | input | 1 | Odd half writable |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_code | output | 2 | 0 HIT, 1 MISS, 2 INVALID, 3 MODIFIED |
| rsp_pa | output | 32 | Physical address on HIT, otherwise 0 |
| rsp_wr_ok | output | 1 | Store permission for the hit half |

## Verification
Every lookup result is due on the first rising edge after the request edge. Table writes take effect on their own edge, so a lookup placed in the same cycle still sees the previous entry. The bench model works out the expected code, address and permission at the request edge from its own list of entries. It computes page size and half selection arithmetically and holds the result in a one-deep pipeline, so the value lines up with the cycle in which the design answers. Outputs are compared on the falling edge of every clock. Each comparison carries the requirement tag of the request that produced the value.

// File: rtl/tlbp_pkg.sv
package tlbp_pkg;
  typedef enum logic [1:0] {
    RES_HIT      = 2'd0,
    RES_MISS     = 2'd1,
    RES_INVALID  = 2'd2,
    RES_MODIFIED = 2'd3
  } tlbp_res_e;
endpackage

// File: rtl/tlbp_store.sv
module tlbp_store #(
  parameter int DEPTH  = 16,
  parameter int VPN_W  = 19,
  parameter int ASID_W = 8,
  parameter int PFN_W  = 20,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              wr_en,
  input  logic [IDX_W-1:0]                  wr_idx,
  input  logic [VPN_W-1:0]                  wr_vpn2,
  input  logic [ASID_W-1:0]                 wr_asid,
  input  logic                              wr_global,
  input  logic [VPN_W-1:0]                  wr_mask,
  input  logic [PFN_W-1:0]                  wr_pfn_even,
  input  logic                              wr_valid_even,
  input  logic                              wr_dirty_even,
  input  logic [PFN_W-1:0]                  wr_pfn_odd,
  input  logic                              wr_valid_odd,
  input  logic                              wr_dirty_odd,
  output logic [DEPTH-1:0][VPN_W-1:0]       ent_vpn,
  output logic [DEPTH-1:0][ASID_W-1:0]      ent_asid,
  output logic [DEPTH-1:0]                  ent_g,
  output logic [DEPTH-1:0][VPN_W-1:0]       ent_mask,
  output logic [DEPTH-1:0][1:0][PFN_W-1:0]  ent_pfn,
  output logic [DEPTH-1:0][1:0]             ent_v,
  output logic [DEPTH-1:0][1:0]             ent_d
);
  logic [DEPTH-1:0] slot_we;

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      slot_we[i] = wr_en && (wr_idx == IDX_W'(i));
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ent_vpn[g]  <= '0;
        ent_asid[g] <= '0;
        ent_g[g]    <= 1'b0;
        ent_mask[g] <= '0;
        ent_pfn[g]  <= '0;
        ent_v[g]    <= '0;
        ent_d[g]    <= '0;
      end else if (slot_we[g]) begin
        ent_vpn[g]  <= wr_vpn2;
        ent_asid[g] <= wr_asid;
        ent_g[g]    <= wr_global;
        ent_mask[g] <= wr_mask;
        ent_pfn[g]  <= {wr_pfn_odd, wr_pfn_even};
        ent_v[g]    <= {wr_valid_odd, wr_valid_even};
        ent_d[g]    <= {wr_dirty_odd, wr_dirty_even};
      end
    end
  end
endmodule

// File: rtl/tlbp_match.sv
module tlbp_match #(
  parameter int DEPTH    = 16,
  parameter int VA_W     = 32,
  parameter int PG_SHIFT = 12,
  parameter int ASID_W   = 8,
  localparam int VPN_W   = VA_W - PG_SHIFT - 1
) (
  input  logic [VA_W-1:0]              va,
  input  logic [ASID_W-1:0]            asid,
  input  logic [DEPTH-1:0][VPN_W-1:0]  ent_vpn,
  input  logic [DEPTH-1:0][ASID_W-1:0] ent_asid,
  input  logic [DEPTH-1:0]             ent_g,
  input  logic [DEPTH-1:0][VPN_W-1:0]  ent_mask,
  output logic [DEPTH-1:0]             hit,
  output logic [DEPTH-1:0]             odd
);
  for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
    logic [VA_W-1:0] emask;
    logic [VA_W-1:0] half_bit;
    logic            tag_eq;
    logic            id_ok;

    assign emask    = {ent_mask[g], {(PG_SHIFT+1){1'b1}}};
    assign half_bit = emask & ~(emask >> 1);
    assign tag_eq   = ((va[VA_W-1:PG_SHIFT+1] ^ ent_vpn[g]) & ~ent_mask[g]) == '0;
    assign id_ok    = ent_g[g] || (ent_asid[g] == asid);
    assign hit[g]   = tag_eq && id_ok;
    assign odd[g]   = |(va & half_bit);
  end
endmodule

// File: rtl/tlbp_resolve.sv
module tlbp_resolve
  import tlbp_pkg::*;
#(
  parameter int DEPTH    = 16,
  parameter int VA_W     = 32,
  parameter int PA_W     = 32,
  parameter int PG_SHIFT = 12,
  localparam int VPN_W   = VA_W - PG_SHIFT - 1,
  localparam int PFN_W   = PA_W - PG_SHIFT,
  localparam int IDX_W   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic [VA_W-1:0]                  va,
  input  logic                             is_write,
  input  logic [DEPTH-1:0]                 hit,
  input  logic [DEPTH-1:0]                 odd,
  input  logic [DEPTH-1:0][VPN_W-1:0]      ent_mask,
  input  logic [DEPTH-1:0][1:0][PFN_W-1:0] ent_pfn,
  input  logic [DEPTH-1:0][1:0]            ent_v,
  input  logic [DEPTH-1:0][1:0]            ent_d,
  output tlbp_res_e                        res_code,
  output logic [PA_W-1:0]                  res_pa,
  output logic                             res_wr_ok
);
  logic             found;
  logic [IDX_W-1:0] sel;
  logic             half;
  logic [VA_W-1:0]  emask;
  logic [PFN_W-1:0] frame;
  logic             h_valid;
  logic             h_dirty;

  // lowest index wins: scan downward so the last assignment is the lowest hit
  always_comb begin
    found = 1'b0;
    sel   = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (hit[i]) begin
        found = 1'b1;
        sel   = IDX_W'(i);
      end
    end
  end

  always_comb begin
    half    = odd[sel];
    emask   = {ent_mask[sel], {(PG_SHIFT+1){1'b1}}};
    frame   = ent_pfn[sel][half];
    h_valid = ent_v[sel][half];
    h_dirty = ent_d[sel][half];

    res_code  = RES_MISS;
    res_pa    = '0;
    res_wr_ok = 1'b0;
    if (found) begin
      if (!h_valid) begin
        res_code = RES_INVALID;
      end else if (is_write && !h_dirty) begin
        res_code = RES_MODIFIED;
      end else begin
        res_code  = RES_HIT;
        res_pa    = {frame, {PG_SHIFT{1'b0}}} | PA_W'(va & (emask >> 1));
        res_wr_ok = h_dirty;
      end
    end
  end
endmodule

// File: rtl/tlbp_lookup_unit.sv
module tlbp_lookup_unit
  import tlbp_pkg::*;
#(
  parameter int DEPTH    = 16,
  parameter int VA_W     = 32,
  parameter int PA_W     = 32,
  parameter int ASID_W   = 8,
  parameter int PG_SHIFT = 12,
  localparam int VPN_W   = VA_W - PG_SHIFT - 1,
  localparam int PFN_W   = PA_W - PG_SHIFT,
  localparam int IDX_W   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [VA_W-1:0]   req_va,
  input  logic [ASID_W-1:0] req_asid,
  input  logic              req_write,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [VPN_W-1:0]  wr_vpn2,
  input  logic [ASID_W-1:0] wr_asid,
  input  logic              wr_global,
  input  logic [VPN_W-1:0]  wr_mask,
  input  logic [PFN_W-1:0]  wr_pfn_even,
  input  logic              wr_valid_even,
  input  logic              wr_dirty_even,
  input  logic [PFN_W-1:0]  wr_pfn_odd,
  input  logic              wr_valid_odd,
  input  logic              wr_dirty_odd,
  output logic              rsp_valid,
  output logic [1:0]        rsp_code,
  output logic [PA_W-1:0]   rsp_pa,
  output logic              rsp_wr_ok
);
  logic [DEPTH-1:0][VPN_W-1:0]      ent_vpn;
  logic [DEPTH-1:0][ASID_W-1:0]     ent_asid;
  logic [DEPTH-1:0]                 ent_g;
  logic [DEPTH-1:0][VPN_W-1:0]      ent_mask;
  logic [DEPTH-1:0][1:0][PFN_W-1:0] ent_pfn;
  logic [DEPTH-1:0][1:0]            ent_v;
  logic [DEPTH-1:0][1:0]            ent_d;
  logic [DEPTH-1:0]                 hit;
  logic [DEPTH-1:0]                 odd;
  tlbp_res_e                        res_code;
  logic [PA_W-1:0]                  res_pa;
  logic                             res_wr_ok;

  logic            valid_d, valid_q;
  logic [1:0]      code_d, code_q;
  logic [PA_W-1:0] pa_d, pa_q;
  logic            wok_d, wok_q;

  tlbp_store #(
    .DEPTH(DEPTH), .VPN_W(VPN_W), .ASID_W(ASID_W), .PFN_W(PFN_W)
  ) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_vpn2(wr_vpn2), .wr_asid(wr_asid), .wr_global(wr_global),
    .wr_mask(wr_mask), .wr_pfn_even(wr_pfn_even),
    .wr_valid_even(wr_valid_even), .wr_dirty_even(wr_dirty_even),
    .wr_pfn_odd(wr_pfn_odd), .wr_valid_odd(wr_valid_odd),
    .wr_dirty_odd(wr_dirty_odd),
    .ent_vpn(ent_vpn), .ent_asid(ent_asid), .ent_g(ent_g),
    .ent_mask(ent_mask), .ent_pfn(ent_pfn), .ent_v(ent_v), .ent_d(ent_d)
  );

  tlbp_match #(
    .DEPTH(DEPTH), .VA_W(VA_W), .PG_SHIFT(PG_SHIFT), .ASID_W(ASID_W)
  ) u_match (
    .va(req_va), .asid(req_asid), .ent_vpn(ent_vpn), .ent_asid(ent_asid),
    .ent_g(ent_g), .ent_mask(ent_mask), .hit(hit), .odd(odd)
  );

  tlbp_resolve #(
    .DEPTH(DEPTH), .VA_W(VA_W), .PA_W(PA_W), .PG_SHIFT(PG_SHIFT)
  ) u_resolve (
    .va(req_va), .is_write(req_write), .hit(hit), .odd(odd),
    .ent_mask(ent_mask), .ent_pfn(ent_pfn), .ent_v(ent_v), .ent_d(ent_d),
    .res_code(res_code), .res_pa(res_pa), .res_wr_ok(res_wr_ok)
  );

  always_comb begin
    valid_d = req_valid;
    code_d  = code_q;
    pa_d    = pa_q;
    wok_d   = wok_q;
    if (req_valid) begin
      code_d = res_code;
      pa_d   = res_pa;
      wok_d  = res_wr_ok;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      code_q  <= RES_MISS;
      pa_q    <= '0;
      wok_q   <= 1'b0;
    end else begin
      valid_q <= valid_d;
      code_q  <= code_d;
      pa_q    <= pa_d;
      wok_q   <= wok_d;
    end
  end

  assign rsp_valid = valid_q;
  assign rsp_code  = code_q;
  assign rsp_pa    = pa_q;
  assign rsp_wr_ok = wok_q;
endmodule

// File: rtl/tlbp_lookup_chk.sv
module tlbp_lookup_chk #(
  parameter int PA_W = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic            req_write,
  input logic            rsp_valid,
  input logic [1:0]      rsp_code,
  input logic [PA_W-1:0] rsp_pa,
  input logic            rsp_wr_ok
);
  logic past_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  // R2
  rsp_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> (rsp_valid == $past(req_valid)));

  // R8
  wr_ok_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_wr_ok) |-> (rsp_code == 2'd0));

  // R6
  pa_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_code != 2'd0) |-> (rsp_pa == '0));

  // R7
  modified_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && rsp_valid && rsp_code == 2'd3) |-> $past(req_write));
endmodule

bind tlbp_lookup_unit tlbp_lookup_chk #(.PA_W(PA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
  .rsp_valid(rsp_valid), .rsp_code(rsp_code), .rsp_pa(rsp_pa),
  .rsp_wr_ok(rsp_wr_ok)
);

// File: tb/tlbp_lookup_unit_tb.sv
module tlbp_lookup_unit_tb;
  localparam int CLK_P = 10;
  localparam int N = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] req_va = '0;
  logic [7:0]  req_asid = '0;
  logic        req_write = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_idx = '0;
  logic [18:0] wr_vpn2 = '0;
  logic [7:0]  wr_asid = '0;
  logic        wr_global = 1'b0;
  logic [18:0] wr_mask = '0;
  logic [19:0] wr_pfn_even = '0, wr_pfn_odd = '0;
  logic        wr_valid_even = 1'b0, wr_dirty_even = 1'b0;
  logic        wr_valid_odd = 1'b0, wr_dirty_odd = 1'b0;
  logic        rsp_valid;
  logic [1:0]  rsp_code;
  logic [31:0] rsp_pa;
  logic        rsp_wr_ok;

  tlbp_lookup_unit u_dut (.*);

  always #(CLK_P/2) clk = ~clk;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  string cur_tag = "R1";

  // behavioural table
  longint unsigned m_vpn [N], m_mask [N], m_pfn0 [N], m_pfn1 [N];
  int unsigned     m_asid [N];
  bit              m_g [N], m_v0 [N], m_v1 [N], m_d0 [N], m_d1 [N];

  bit              exp_valid;
  int              exp_code;
  longint unsigned exp_pa;
  bit              exp_wok;
  string           exp_tag;

  task automatic ref_lookup(input longint unsigned va, input int unsigned asid,
                            input bit wr, output int code,
                            output longint unsigned pa, output bit wok);
    code = 1; pa = 0; wok = 0;
    for (int i = 0; i < N; i++) begin
      int k = $countones(m_mask[i]);
      if ((m_g[i] || m_asid[i] == asid) && ((va >> (13 + k)) == (m_vpn[i] >> k))) begin
        longint unsigned psize = 64'd4096 << k;
        bit isodd = ((va / psize) % 2) == 1;
        bit v = isodd ? m_v1[i] : m_v0[i];
        bit d = isodd ? m_d1[i] : m_d0[i];
        if (!v) code = 2;
        else if (wr && !d) code = 3;
        else begin
          code = 0;
          pa   = ((isodd ? m_pfn1[i] : m_pfn0[i]) * 4096) + (va % psize);
          wok  = d;
        end
        return;
      end
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exp_valid = 0;
      for (int i = 0; i < N; i++) begin
        m_vpn[i] = 0; m_mask[i] = 0; m_pfn0[i] = 0; m_pfn1[i] = 0;
        m_asid[i] = 0; m_g[i] = 0; m_v0[i] = 0; m_v1[i] = 0;
        m_d0[i] = 0; m_d1[i] = 0;
      end
    end else begin
      exp_valid = req_valid;
      if (req_valid) begin
        ref_lookup(req_va, req_asid, req_write, exp_code, exp_pa, exp_wok);
        exp_tag = cur_tag;
      end
      if (wr_en) begin
        m_vpn[wr_idx] = wr_vpn2; m_mask[wr_idx] = wr_mask; m_asid[wr_idx] = wr_asid;
        m_g[wr_idx] = wr_global; m_pfn0[wr_idx] = wr_pfn_even; m_pfn1[wr_idx] = wr_pfn_odd;
        m_v0[wr_idx] = wr_valid_even; m_v1[wr_idx] = wr_valid_odd;
        m_d0[wr_idx] = wr_dirty_even; m_d1[wr_idx] = wr_dirty_odd;
      end
    end
  end

  task automatic check(input string tag, input longint unsigned act, input longint unsigned exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      check({"R2 rsp_valid ", exp_tag}, rsp_valid, exp_valid);
      if (exp_valid) begin
        check({exp_tag, " code"}, rsp_code, exp_code);
        check({exp_tag, " pa"}, rsp_pa, exp_pa);
        check({exp_tag, " wr_ok"}, rsp_wr_ok, exp_wok);
      end
    end
  end

  task automatic finish_run();
    done = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  task automatic look(input logic [31:0] va, input logic [7:0] asid,
                      input bit wr, input string tag);
    @(negedge clk);
    req_valid = 1; req_va = va; req_asid = asid; req_write = wr; cur_tag = tag;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      req_valid = 0; wr_en = 0;
    end
  endtask

  task automatic put(input int idx, input logic [18:0] vpn, input logic [7:0] asid,
                     input bit g, input logic [18:0] mask,
                     input logic [19:0] p0, input bit v0, input bit d0,
                     input logic [19:0] p1, input bit v1, input bit d1);
    @(negedge clk);
    req_valid = 0;
    wr_en = 1; wr_idx = 4'(idx); wr_vpn2 = vpn; wr_asid = asid; wr_global = g;
    wr_mask = mask; wr_pfn_even = p0; wr_valid_even = v0; wr_dirty_even = d0;
    wr_pfn_odd = p1; wr_valid_odd = v1; wr_dirty_odd = d1;
    @(negedge clk);
    wr_en = 0;
  endtask

  initial begin
    #(CLK_P * 60000);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 rsp_valid after reset", rsp_valid, 0);

    look(32'h0000_0000, 8'd0, 0, "R1 zeroed entry gives invalid");
    look(32'h0040_0000, 8'd0, 0, "R9 miss after reset");
    idle(1);

    // entry 3: 4 KB pages at 0x0040_0000, identifier 5
    put(3, 19'h00200, 8'd5, 0, 19'h0, 20'h11111, 1, 0, 20'h22222, 1, 1);
    look(32'h0040_0123, 8'd5, 0, "R6 even read hit");
    look(32'h0040_1abc, 8'd5, 0, "R4 odd half by bit 12");
    look(32'h0040_0456, 8'd5, 1, "R7 store to clean half");
    look(32'h0040_1fff, 8'd5, 1, "R8 store to dirty half");
    look(32'h0040_0000, 8'd6, 0, "R3 identifier mismatch");
    look(32'h0040_2000, 8'd5, 0, "R9 next pair misses");
    idle(1);

    // entry 7: global, same pair, different frames
    put(7, 19'h00200, 8'd9, 1, 19'h0, 20'h33333, 1, 1, 20'h44444, 0, 0);
    look(32'h0040_0010, 8'd5, 0, "R10 lowest index wins");
    look(32'h0040_0010, 8'd6, 1, "R3 global entry any identifier");
    look(32'h0040_1010, 8'd6, 0, "R5 odd half not valid");
    idle(1);

    // entry 9: 16 KB pages, tag low bits set under the mask
    put(9, 19'h08003, 8'd1, 0, 19'h00003, 20'h40000, 0, 0, 20'h50000, 1, 1);
    look(32'h1000_3456, 8'd1, 0, "R5 even half of large page invalid");
    look(32'h1000_4456, 8'd1, 0, "R4 odd half by bit 14");
    look(32'h1000_7fff, 8'd1, 1, "R6 large page offset");
    look(32'h1000_8000, 8'd1, 0, "R9 beyond large pair");
    look(32'h1000_5000, 8'd1, 1, "R3 masked tag bits ignored");
    idle(1);

    // same-cycle write and lookup, then rewrite of entry 3
    @(negedge clk);
    req_valid = 1; req_va = 32'h0040_0123; req_asid = 8'd5; req_write = 0;
    cur_tag = "R11 lookup in write cycle sees old";
    wr_en = 1; wr_idx = 4'd3; wr_vpn2 = 19'h00200; wr_asid = 8'd5; wr_global = 0;
    wr_mask = 0; wr_pfn_even = 20'h77777; wr_valid_even = 0; wr_dirty_even = 0;
    wr_pfn_odd = 20'h66666; wr_valid_odd = 1; wr_dirty_odd = 0;
    @(negedge clk);
    wr_en = 0; cur_tag = "R11 rewritten entry";
    look(32'h0040_0123, 8'd5, 0, "R11 rewritten even half invalid");
    look(32'h0040_1123, 8'd5, 1, "R11 rewritten odd half clean");
    look(32'h0040_1123, 8'd5, 0, "R11 rewritten odd read");
    idle(2);

    // mixed sweep, back-to-back and gapped
    for (int t = 0; t < 400; t++) begin
      logic [31:0] base;
      int sel = $urandom_range(0, 2);
      base = (sel == 0) ? 32'h0040_0000 : (sel == 1) ? 32'h1000_0000 : 32'h0000_0000;
      if ($urandom_range(0, 3) == 0) idle(1);
      look(base + 32'($urandom_range(0, 32'hFFFF)), 8'($urandom_range(0, 7)),
           1'($urandom_range(0, 1)), "R2 mixed sweep");
    end
    idle(3);
    finish_run();
  end
endmodule